// File: doc/BRIEF.md
# Software-Stack Instruction Extension Unit

This unit sits beside the decoder of an 8-bit microcontroller core and runs a small group of optional 16-bit instructions. They serve compiled code that keeps its locals on a software stack. The unit holds three 12-bit data pointers, and pointer 2 serves as the software stack pointer. From one fetched word per cycle it adds or subtracts short literals on a pointer, pushes a literal byte onto the stack, calls through an address built from the working register, and copies bytes from the stack frame to an absolute or frame-relative location. Every operation leaves the status flags alone.

The unit drives a synchronous byte-wide data port with a one-cycle read latency. It raises one-cycle call and return requests toward the program-counter and return-stack logic. While it needs a second cycle for a call or a return it raises `busy`, and the fetch side must hold its next word for that cycle. Two-word moves take their second word whenever the fetch delivers it. A configuration input enables the whole extension. When that input is low, every encoding listed here does nothing.

Top module: `sstack_ext_unit`

## Requirements
- R1: Word `1110 1000 ffkk kkkk` with ff = 0, 1 or 2 adds the unsigned 6-bit k to pointer ff, modulo 4096. The new value shows on `ptr_view` (pointer n at bits 12n+11..12n) after the accepting clock edge. No memory access takes place, and `busy`, `ret_req` and `call_req` stay low.
- R2: Word `1110 1001 ffkk kkkk` with ff = 0, 1 or 2 subtracts k from pointer ff, modulo 4096, with the same timing as R1.
- R3: In either word, ff = 11 applies the add or subtract to pointer 2. `ret_req` and `busy` are then high for exactly the one cycle after the accepting edge.
- R4: Word `1110 1010 kkkk kkkk` drives `mem_we`=1, `mem_addr`=pointer 2 and `mem_wdata`=k in its own cycle. Pointer 2 then decrements by one, modulo 4096.
- R5: Word `0x0014` makes `call_req` and `busy` high for the one cycle after the accepting edge. `call_target` is {`pc_upper`,`pc_high`,`wreg`} and `call_push_addr` is `next_pc`, both sampled at acceptance.
- R6: First word `1110 1011 0zzz zzzz` reads address pointer2+z in its own cycle (`mem_re`=1). A second word `1111 aaaa aaaa aaaa`, arriving in any later cycle, writes the byte read to address a in its own cycle.
- R7: First word `1110 1011 1zzz zzzz` reads pointer2+z. The second word `1111 xxxx xddd dddd` writes the byte to pointer2+d, and bits 11..7 of that word have no effect on the destination.
- R8: With `ext_en` low, no encoding causes a memory access, a pointer change, a call or a return.
- R9: A word with top nibble `1111` and no pending first word is a no-operation. Any other word that arrives while a second word is awaited cancels the move with no write, and that word itself is not executed.
- R10: Words outside the listed encodings have no effect on pointers, memory, calls or returns.
- R11: After reset all pointers are zero, and `busy`, `ret_req`, `call_req`, `mem_we` and `mem_re` are low.
- R12: A word presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Configuration enable for the extension |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_word | input | 16 | Fetched instruction word |
| wreg | input | 8 | Working register contents |
| pc_upper | input | 5 | Upper program-counter latch |
| pc_high | input | 8 | High program-counter latch |
| next_pc | input | 21 | Address of the next instruction |
| busy | output | 1 | Second cycle of a call or return; fetch holds |
| mem_addr | output | 12 | Data memory address |
| mem_re | output | 1 | Data memory read strobe |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | 8 | Data memory write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after `mem_re` |
| call_req | output | 1 | Call request pulse |
| call_target | output | 21 | Call destination |
| call_push_addr | output | 21 | Return address to push |
| ret_req | output | 1 | Return request pulse |
| ptr_view | output | 36 | The three pointers, pointer n at bits 12n+11..12n |

## Verification
A wrong pointer value shows on `ptr_view` one edge after the instruction that produced it. It also shows on `mem_addr` in the same cycle as the next push or stack-relative move. A move sequencer stuck pending swallows the next ordinary instruction, so the pointer views stop tracking the model at the following edge. Losing the captured read byte shows up only at the second word, as a wrong `mem_wdata`, and delayed second words make this visible. A broken busy or return register shows as a request pulse that is missing, too long, or lets a word through during `busy`.

// File: rtl/sx_pkg.sv
package sx_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADDP,
    OP_SUBP,
    OP_ADDRET,
    OP_SUBRET,
    OP_PUSH,
    OP_CALLW,
    OP_MOVSF1,
    OP_MOVSS1,
    OP_WORD2
  } sx_op_e;

  typedef struct packed {
    sx_op_e      op;
    logic [1:0]  sel;
    logic [7:0]  lit;
    logic [6:0]  off;
    logic [11:0] abs_addr;
  } sx_dec_t;

  localparam logic [15:0] SX_CALLW_WORD = 16'h0014;
  localparam logic [3:0]  SX_WORD2_TAG  = 4'hF;

endpackage

// File: rtl/sx_decode.sv
module sx_decode
  import sx_pkg::*;
(
  input  logic [15:0] word,
  input  logic        valid,
  input  logic        enable,
  input  logic        hold,
  input  logic        want_second,
  output sx_dec_t     dec,
  output logic        abandon
);

  logic accept;
  logic is_word2;

  assign accept   = valid && enable && !hold;
  assign is_word2 = (word[15:12] == SX_WORD2_TAG);
  assign abandon  = accept && want_second && !is_word2;

  always_comb begin
    dec          = '0;
    dec.op       = OP_NONE;
    dec.sel      = word[7:6];
    dec.lit      = word[7:0];
    dec.off      = word[6:0];
    dec.abs_addr = word[11:0];
    if (accept) begin
      if (want_second) begin
        if (is_word2) dec.op = OP_WORD2;
      end else if (word == SX_CALLW_WORD) begin
        dec.op = OP_CALLW;
      end else begin
        case (word[15:8])
          8'hE8:   dec.op = (&word[7:6]) ? OP_ADDRET : OP_ADDP;
          8'hE9:   dec.op = (&word[7:6]) ? OP_SUBRET : OP_SUBP;
          8'hEA:   dec.op = OP_PUSH;
          8'hEB:   dec.op = word[7] ? OP_MOVSS1 : OP_MOVSF1;
          default: dec.op = OP_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sx_ptr_file.sv
module sx_ptr_file #(
  parameter int AW   = 12,
  parameter int NPTR = 3,
  localparam int IW  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en,
  input  logic [IW-1:0]            upd_idx,
  input  logic [AW-1:0]            upd_val,
  output logic [NPTR-1:0][AW-1:0]  ptr
);

  logic [AW-1:0] q [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (upd_en && (upd_idx == IW'(g))) begin
        q[g] <= upd_val;
      end
    end
    assign ptr[g] = q[g];
  end

  // R1: an update never names a pointer that does not exist
  a_r1_idx_in_range : assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (int'(upd_idx) < NPTR));

endmodule

// File: rtl/sx_move_seq.sv
module sx_move_seq #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          start_sf,
  input  logic          start_ss,
  input  logic          word2,
  input  logic          abandon,
  input  logic [6:0]    src_off,
  input  logic [6:0]    dst_off,
  input  logic [11:0]   dst_abs,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] rdata,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          pending
);

  function automatic logic [AW-1:0] frame_addr(input logic [AW-1:0] b,
                                               input logic [6:0] o);
    return b + AW'(o);
  endfunction

  logic          pend_q;
  logic          ss_q;
  logic          fresh_q;
  logic [DW-1:0] hold_q;

  assign rd_en   = start_sf || start_ss;
  assign rd_addr = frame_addr(base, src_off);
  assign wr_en   = pend_q && word2;
  assign wr_addr = ss_q ? frame_addr(base, dst_off) : AW'(dst_abs);
  assign wr_data = fresh_q ? rdata : hold_q;
  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      ss_q    <= 1'b0;
      fresh_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      fresh_q <= rd_en;
      if (fresh_q) hold_q <= rdata;
      if (rd_en) begin
        pend_q <= 1'b1;
        ss_q   <= start_ss;
      end else if (pend_q && (word2 || abandon || !enable)) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R6: a pending move was always opened by a read one cycle earlier
  a_r6_pend_from_read : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(rd_en));

  // R9: no new move starts while one awaits its second word
  a_r9_no_restart : assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !rd_en);

endmodule

// File: rtl/sstack_ext_unit.sv
module sstack_ext_unit
  import sx_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 8,
  parameter int PCW  = 21,
  parameter int NPTR = 3,
  localparam int UPW    = PCW - 2*DW,
  localparam int IW     = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int SP_IDX = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_en,
  input  logic                instr_valid,
  input  logic [15:0]         instr_word,
  input  logic [DW-1:0]       wreg,
  input  logic [UPW-1:0]      pc_upper,
  input  logic [DW-1:0]       pc_high,
  input  logic [PCW-1:0]      next_pc,
  output logic                busy,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_re,
  output logic                mem_we,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  output logic                call_req,
  output logic [PCW-1:0]      call_target,
  output logic [PCW-1:0]      call_push_addr,
  output logic                ret_req,
  output logic [NPTR*AW-1:0]  ptr_view
);

  function automatic logic [AW-1:0] ptr_add(input logic [AW-1:0] b,
                                            input logic [5:0] k);
    return b + AW'(k);
  endfunction

  function automatic logic [AW-1:0] ptr_sub(input logic [AW-1:0] b,
                                            input logic [5:0] k);
    return b - AW'(k);
  endfunction

  sx_dec_t dec;
  logic    abandon;
  logic    mv_pending;

  logic busy_q, ret_q, call_q;
  logic [PCW-1:0] tgt_q, push_q;

  sx_decode u_dec (
    .word        (instr_word),
    .valid       (instr_valid),
    .enable      (ext_en),
    .hold        (busy_q),
    .want_second (mv_pending),
    .dec         (dec),
    .abandon     (abandon)
  );

  // named events for checking
  logic fire_add, fire_sub, fire_ret, fire_push, fire_call;
  assign fire_add  = (dec.op == OP_ADDP) || (dec.op == OP_ADDRET);
  assign fire_sub  = (dec.op == OP_SUBP) || (dec.op == OP_SUBRET);
  assign fire_ret  = (dec.op == OP_ADDRET) || (dec.op == OP_SUBRET);
  assign fire_push = (dec.op == OP_PUSH);
  assign fire_call = (dec.op == OP_CALLW);

  logic [NPTR-1:0][AW-1:0] ptr_arr;
  logic [AW-1:0] sp;
  logic          upd_en;
  logic [IW-1:0] upd_idx;
  logic [AW-1:0] upd_base, upd_val;

  assign sp      = ptr_arr[SP_IDX];
  assign upd_en  = fire_add || fire_sub || fire_push;
  assign upd_idx = (fire_push || (&dec.sel)) ? IW'(SP_IDX) : IW'(dec.sel);
  assign upd_base = ptr_arr[upd_idx];
  assign upd_val = fire_push ? ptr_sub(upd_base, 6'd1)
                 : fire_add  ? ptr_add(upd_base, dec.lit[5:0])
                 :             ptr_sub(upd_base, dec.lit[5:0]);

  sx_ptr_file #(.AW(AW), .NPTR(NPTR)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .upd_idx (upd_idx),
    .upd_val (upd_val),
    .ptr     (ptr_arr)
  );

  logic          mv_rd, mv_wr;
  logic [AW-1:0] mv_rd_addr, mv_wr_addr;
  logic [DW-1:0] mv_wdata;

  sx_move_seq #(.AW(AW), .DW(DW)) u_move (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (ext_en),
    .start_sf (dec.op == OP_MOVSF1),
    .start_ss (dec.op == OP_MOVSS1),
    .word2    (dec.op == OP_WORD2),
    .abandon  (abandon),
    .src_off  (dec.off),
    .dst_off  (dec.off),
    .dst_abs  (dec.abs_addr),
    .base     (sp),
    .rdata    (mem_rdata),
    .rd_en    (mv_rd),
    .rd_addr  (mv_rd_addr),
    .wr_en    (mv_wr),
    .wr_addr  (mv_wr_addr),
    .wr_data  (mv_wdata),
    .pending  (mv_pending)
  );

  assign mem_we    = fire_push || mv_wr;
  assign mem_re    = mv_rd;
  assign mem_addr  = fire_push ? sp : (mv_rd ? mv_rd_addr : mv_wr_addr);
  assign mem_wdata = fire_push ? dec.lit : mv_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ret_q  <= 1'b0;
      call_q <= 1'b0;
      tgt_q  <= '0;
      push_q <= '0;
    end else begin
      busy_q <= fire_ret || fire_call;
      ret_q  <= fire_ret;
      call_q <= fire_call;
      if (fire_call) begin
        tgt_q  <= {pc_upper, pc_high, wreg};
        push_q <= next_pc;
      end
    end
  end

  assign busy           = busy_q;
  assign ret_req        = ret_q;
  assign call_req       = call_q;
  assign call_target    = tgt_q;
  assign call_push_addr = push_q;
  assign ptr_view       = ptr_arr;

  // R3: a return request follows only a return-form pointer operation
  a_r3_ret_after_fire : assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |-> $past(fire_ret));

  // R5: the call request lasts a single cycle
  a_r5_call_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);

  // R4: a push leaves the stack pointer one lower
  a_r4_push_dec : assert property (@(posedge clk) disable iff (!rst_n)
    fire_push |=> (sp == $past(sp) - AW'(1)));

  // R8: disabled extension touches neither memory nor pointers
  a_r8_quiet_mem : assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> (!mem_we && !mem_re));
  a_r8_ptrs_frozen : assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |=> $stable(ptr_view));

  // R12: nothing reaches memory during the busy cycle
  a_r12_busy_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!mem_we && !mem_re));

  // R6: the data port never reads and writes at once
  a_r6_port_excl : assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

endmodule

// File: tb/sstack_ext_unit_bench.sv
module sstack_ext_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_en;
  logic        instr_valid;
  logic [15:0] instr_word;
  logic [7:0]  wreg;
  logic [4:0]  pc_upper;
  logic [7:0]  pc_high;
  logic [20:0] next_pc;
  logic        busy;
  logic [11:0] mem_addr;
  logic        mem_re, mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        call_req, ret_req;
  logic [20:0] call_target, call_push_addr;
  logic [35:0] ptr_view;

  always #5 clk = ~clk;

  sstack_ext_unit u_sstack_ext_unit (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en),
    .instr_valid(instr_valid), .instr_word(instr_word),
    .wreg(wreg), .pc_upper(pc_upper), .pc_high(pc_high), .next_pc(next_pc),
    .busy(busy), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .call_req(call_req), .call_target(call_target),
    .call_push_addr(call_push_addr), .ret_req(ret_req), .ptr_view(ptr_view)
  );

  logic [7:0] mem [4096];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  int checks = 0;
  int fails  = 0;
  logic [11:0] m_ptr [3];

  logic        s_we, s_re;
  logic [11:0] s_addr;
  logic [7:0]  s_wd;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] f_add(input logic [11:0] p, input int k);
    return p + 12'(k);
  endfunction

  // drive a word at the falling edge, sample the port, pass the rising edge
  task automatic go(input logic [15:0] w, input bit v);
    @(negedge clk);
    instr_word  = w;
    instr_valid = v;
    #1;
    s_we = mem_we; s_re = mem_re; s_addr = mem_addr; s_wd = mem_wdata;
    @(posedge clk);
    #1;
    instr_valid = 1'b0;
  endtask

  task automatic chk_ptrs(input string req);
    for (int i = 0; i < 3; i++)
      chk(ptr_view[i*12 +: 12] == m_ptr[i], req, "pointer",
          int'(ptr_view[i*12 +: 12]), int'(m_ptr[i]));
  endtask

  task automatic exec_addsub(input bit sub, input logic [1:0] ff,
                             input logic [5:0] k);
    int idx;
    string rq;
    idx = (ff == 2'b11) ? 2 : int'(ff);
    rq  = (ff == 2'b11) ? "R3" : (sub ? "R2" : "R1");
    go({7'b1110100, sub, ff, k}, 1'b1);
    chk(!s_we && !s_re, rq, "no memory access", int'({s_we, s_re}), 0);
    m_ptr[idx] = sub ? f_add(m_ptr[idx], -int'(k)) : f_add(m_ptr[idx], int'(k));
    chk_ptrs(rq);
    if (ff == 2'b11) begin
      chk(ret_req && busy, "R3", "return and busy", int'({ret_req, busy}), 3);
      go(16'hEA55, 1'b1);   // R12: this push arrives while busy
      chk(!s_we, "R12", "push ignored while busy", int'(s_we), 0);
      chk_ptrs("R12");
      chk(!ret_req && !busy, "R3", "return one cycle", int'({ret_req, busy}), 0);
    end else begin
      chk(!ret_req && !busy && !call_req, rq, "no request",
          int'({ret_req, busy, call_req}), 0);
    end
  endtask

  task automatic exec_push(input logic [7:0] k);
    go({8'hEA, k}, 1'b1);
    chk(s_we && s_addr == m_ptr[2] && s_wd == k, "R4", "push write",
        int'({s_we, s_addr, s_wd}), int'({1'b1, m_ptr[2], k}));
    m_ptr[2] = f_add(m_ptr[2], -1);
    chk_ptrs("R4");
  endtask

  task automatic exec_callw();
    logic [20:0] tgt, ret;
    wreg = 8'($urandom); pc_upper = 5'($urandom); pc_high = 8'($urandom);
    next_pc = 21'($urandom);
    tgt = {pc_upper, pc_high, wreg};
    ret = next_pc;
    go(16'h0014, 1'b1);
    wreg = 8'($urandom); next_pc = 21'($urandom);
    chk(call_req && busy, "R5", "call and busy", int'({call_req, busy}), 3);
    chk(call_target == tgt, "R5", "call target", int'(call_target), int'(tgt));
    chk(call_push_addr == ret, "R5", "push address", int'(call_push_addr), int'(ret));
    chk(!ret_req, "R5", "no return", int'(ret_req), 0);
    go(16'h0000, 1'b0);
    chk(!call_req && !busy, "R5", "call one cycle", int'({call_req, busy}), 0);
    chk_ptrs("R5");
  endtask

  task automatic exec_move(input bit ss, input logic [6:0] z,
                           input logic [11:0] dest_field, input int gap,
                           input logic [4:0] xbits);
    logic [11:0] src, dst;
    logic [7:0]  exp;
    string rq;
    rq  = ss ? "R7" : "R6";
    src = f_add(m_ptr[2], int'(z));
    dst = ss ? f_add(m_ptr[2], int'(dest_field[6:0])) : dest_field;
    go({8'hEB, ss, z}, 1'b1);
    chk(s_re && !s_we && s_addr == src, rq, "source read",
        int'({s_re, s_addr}), int'({1'b1, src}));
    exp = mem[src];
    for (int i = 0; i < gap; i++) begin
      go(16'h0000, 1'b0);
      chk(!s_we, rq, "no early write", int'(s_we), 0);
    end
    go(ss ? {4'hF, xbits, dest_field[6:0]} : {4'hF, dest_field}, 1'b1);
    chk(s_we && s_addr == dst, rq, "destination write",
        int'({s_we, s_addr}), int'({1'b1, dst}));
    chk(s_wd == exp, rq, "moved byte", int'(s_wd), int'(exp));
    chk_ptrs(rq);
  endtask

  task automatic exec_noeffect(input logic [15:0] w, input string rq);
    go(w, 1'b1);
    chk(!s_we && !s_re, rq, "no memory access", int'({s_we, s_re}), 0);
    chk(!ret_req && !call_req && !busy, rq, "no request",
        int'({ret_req, call_req, busy}), 0);
    chk_ptrs(rq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 3; i++) m_ptr[i] = 12'h000;
    rst_n = 1'b0; ext_en = 1'b1; instr_valid = 1'b0; instr_word = 16'h0;
    wreg = 8'h0; pc_upper = 5'h0; pc_high = 8'h0; next_pc = 21'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    chk_ptrs("R11");
    chk(!busy && !ret_req && !call_req && !mem_we && !mem_re, "R11", "quiet outputs",
        int'({busy, ret_req, call_req, mem_we, mem_re}), 0);

    // directed corner cases
    exec_addsub(1'b1, 2'd0, 6'd1);     // R2 wrap below zero -> FFF
    exec_addsub(1'b0, 2'd0, 6'd63);    // R1 wrap past FFF
    exec_addsub(1'b0, 2'd1, 6'd40);
    exec_addsub(1'b0, 2'd2, 6'd20);
    exec_addsub(1'b0, 2'b11, 6'd5);    // R3 add-and-return
    exec_addsub(1'b1, 2'b11, 6'd3);    // R3 subtract-and-return
    exec_push(8'hA5);
    exec_callw();
    exec_move(1'b0, 7'd0, 12'h300, 0, 5'd0);
    exec_move(1'b0, 7'd127, 12'hFFF, 2, 5'd0);
    exec_move(1'b1, 7'd3, 12'h07F, 1, 5'h1F);   // R7 ignored bits all set

    // R9: stray second word, then a cancelled move
    exec_noeffect(16'hF123, "R9");
    go({8'hEB, 1'b0, 7'd4}, 1'b1);
    chk(s_re, "R9", "move opened", int'(s_re), 1);
    exec_noeffect(16'hE805, "R9");     // cancels, add not executed
    exec_noeffect(16'hF200, "R9");     // no longer pending

    // R10: unlisted encodings
    exec_noeffect(16'h1234, "R10");
    exec_noeffect(16'hE000, "R10");
    exec_noeffect(16'h0015, "R10");
    exec_noeffect(16'hECFF, "R10");

    // R8: extension disabled
    ext_en = 1'b0;
    exec_noeffect(16'hEA77, "R8");
    exec_noeffect(16'hE83F, "R8");
    exec_noeffect(16'hE9C2, "R8");
    exec_noeffect(16'h0014, "R8");
    exec_noeffect({8'hEB, 8'h05}, "R8");
    ext_en = 1'b1;

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int kind;
      kind = int'($urandom_range(0, 9));
      case (kind)
        0, 1: exec_addsub(1'b0, 2'($urandom_range(0, 3)), 6'($urandom));
        2, 3: exec_addsub(1'b1, 2'($urandom_range(0, 3)), 6'($urandom));
        4:    exec_push(8'($urandom));
        5:    exec_callw();
        6:    exec_move(1'b0, 7'($urandom), 12'($urandom),
                        int'($urandom_range(0, 2)), 5'd0);
        7:    exec_move(1'b1, 7'($urandom), 12'($urandom),
                        int'($urandom_range(0, 2)), 5'($urandom));
        8:    exec_noeffect({4'hF, 12'($urandom)}, "R9");
        default: exec_noeffect({8'($urandom_range(8'h10, 8'hDF)), 8'($urandom)}, "R10");
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule